// File: doc/BRIEF.md
# Text-Mode Character Generator

This block turns a screen of character codes into the serial pixel stream of an 80-column monochrome text display. It runs on the pixel clock. Two free-running counters give the horizontal position within an 800-clock line and the vertical position within the frame. From these counters the block derives horizontal sync, vertical sync and a display-active flag.

For each character cell a three-stage fetch runs ahead of the visible region. The first stage reads the character code from an on-chip character store. The second stage uses that code and the current scan row to read one glyph row from an internal font store. The third stage loads that row in parallel into a shift register, which then sends out one pixel per clock. The stages sit one clock apart and are timed so that the first pixel of column 0 appears on the first active clock of the line.

A host writes screen contents through a simple write port. Writes take effect on the next fetch that reads the written cell. The font store is filled at start-up with a computed glyph pattern.

Top module: `txtvid_chargen`

## Requirements
- R1: `hsync_o` is high while the horizontal count is 0 to 95 of each 800-clock line and low for counts 96 to 799. The first line starts with count 0 on the first clock after reset is released.
- R2: `vsync_o` is high during lines 0 and 1 of the frame (V_TOTAL lines, 525 by default) and low on every other line.
- R3: `active_o` is high exactly for horizontal counts 144 to 783 on visible lines. Visible lines are V_START to V_START+V_ACTIVE-1, which is lines 35 to 514 by default. It is low everywhere else.
- R4: On a visible line, column c (0 to 79) gives a one-clock `char_fetch_o` at count 141+8c, a one-clock `glyph_fetch_o` at 142+8c and a one-clock `shift_load_o` at 143+8c. No strobe occurs after column 79 or on lines that are not visible.
- R5: At count 144+8c+b on visible line V_START+16t+s, `pixel_o` equals bit 7-b of font byte (code-32)*16+s. Here code is the character stored at address t*80+c, so bits go out most significant first.
- R6: The font byte at address a is 0 for a below 16, which makes code 32 (space) blank. For every other address it is (37*a+11) mod 256, and codes 33 to 127 are all usable.
- R7: A character code below 32 or above 127 displays as a blank cell, with every pixel 0.
- R8: `pixel_o` is 0 whenever `active_o` is low.
- R9: A write with `host_we_i` high stores `host_data_i` at `host_addr_i`, and later frames show the new code at that cell.
- R10: While `rst_i` is high, both counters are held at 0. `hsync_o` and `vsync_o` are high, and `active_o`, `pixel_o` and all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| host_we_i | input | 1 | Host write enable for the character store |
| host_addr_i | input | 12 | Host write address (row*80+column) |
| host_data_i | input | 8 | Character code to store |
| hsync_o | output | 1 | Horizontal sync, high while asserted |
| vsync_o | output | 1 | Vertical sync, high while asserted |
| active_o | output | 1 | Display-active flag |
| pixel_o | output | 1 | Serial pixel, 1 = lit |
| char_fetch_o | output | 1 | Character-store read strobe |
| glyph_fetch_o | output | 1 | Font-store read strobe |
| shift_load_o | output | 1 | Shift-register parallel-load strobe |

## Verification
The screen is filled with codes that step through the glyph set at different strides on each text row. A mis-wired row multiply or column index therefore shows up as a wrong glyph, and a reversed shift order turns every byte around. Single cells hold a space, the last glyph and codes just outside the printable range (0x05, 0x1F, 0x80, 0xFF). These separate the blank-glyph path from the range check in the font stage. The whole screen is rewritten during vertical blanking, and the second frame must show the new contents, which proves host writes land at the addresses the fetch reads. Every output is predicted on every clock for two frames, so a strobe or sync edge that lands one count early or late is caught.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;

   // Glyph geometry and code range of the font store
   localparam int unsigned GLYPH_W     = 8;
   localparam int unsigned GLYPH_H     = 16;
   localparam int unsigned CODE_W      = 8;
   localparam int unsigned FIRST_CODE  = 32;
   localparam int unsigned GLYPH_COUNT = 96;
   localparam int unsigned FONT_DEPTH  = GLYPH_COUNT * GLYPH_H;

   // Clocks between the character read strobe and the first pixel of a cell
   localparam int unsigned PRIME_LEAD  = 3;

   typedef logic [GLYPH_W-1:0] glyph_row_t;
   typedef logic [CODE_W-1:0]  char_code_t;

   // Start-up contents of the font store: glyph 0 (space) is blank
   function automatic glyph_row_t font_pattern(input int unsigned a);
      if (a < GLYPH_H) return '0;
      return glyph_row_t'((a * 37 + 11) % 256);
   endfunction

endpackage

// File: rtl/txtvid_timing.sv
module txtvid_timing
   import txtvid_pkg::*;
#(
   parameter int unsigned H_TOTAL   = 800,
   parameter int unsigned H_SYNC    = 96,
   parameter int unsigned H_START   = 144,
   parameter int unsigned H_VISIBLE = 640,
   parameter int unsigned V_TOTAL   = 525,
   parameter int unsigned V_SYNC    = 2,
   parameter int unsigned V_START   = 35,
   parameter int unsigned V_ACTIVE  = 480,
   parameter bit          SYNC_HIGH = 1'b1,
   localparam int unsigned HW       = $clog2(H_TOTAL + 1),
   localparam int unsigned VW       = $clog2(V_TOTAL + 1)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   output logic [HW-1:0] h_o,
   output logic [VW-1:0] v_o,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          active_o
);

   localparam int unsigned H_END = H_START + H_VISIBLE;
   localparam int unsigned V_END = V_START + V_ACTIVE;

   logic [HW-1:0] h_q, h_n;
   logic [VW-1:0] v_q, v_n;
   logic          h_wrap;
   logic          hs_q, vs_q, act_q;

   always_comb begin
      h_wrap = (h_q == HW'(H_TOTAL - 1));
      h_n    = h_wrap ? '0 : h_q + 1'b1;
      v_n    = v_q;
      if (h_wrap) begin
         v_n = (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
      end
   end

   // Flags are computed from the next count so they line up with the counters
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         h_q   <= '0;
         v_q   <= '0;
         hs_q  <= 1'b1;
         vs_q  <= 1'b1;
         act_q <= 1'b0;
      end else begin
         h_q   <= h_n;
         v_q   <= v_n;
         hs_q  <= (h_n < HW'(H_SYNC));
         vs_q  <= (v_n < VW'(V_SYNC));
         act_q <= (h_n >= HW'(H_START)) && (h_n < HW'(H_END)) &&
                  (v_n >= VW'(V_START)) && (v_n < VW'(V_END));
      end
   end

   generate
      if (SYNC_HIGH) begin : g_sync_pos
         assign hsync_o = hs_q;
         assign vsync_o = vs_q;
      end else begin : g_sync_neg
         assign hsync_o = ~hs_q;
         assign vsync_o = ~vs_q;
      end
   endgenerate

   assign h_o      = h_q;
   assign v_o      = v_q;
   assign active_o = act_q;

   assert_hsync_starts_line_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(hs_q) |-> (h_q == '0));

   assert_hcount_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      h_q < HW'(H_TOTAL));

   assert_vsync_starts_frame_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(vs_q) |-> (v_q == '0 && h_q == '0));

   assert_active_rise_at_start_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(act_q) |-> (h_q == HW'(H_START)));

endmodule

// File: rtl/txtvid_fetch.sv
module txtvid_fetch
   import txtvid_pkg::*;
#(
   parameter int unsigned H_START    = 144,
   parameter int unsigned COLS       = 80,
   parameter int unsigned V_START    = 35,
   parameter int unsigned V_ACTIVE   = 480,
   parameter int unsigned CHAR_DEPTH = 2560,
   parameter int unsigned HW         = 10,
   parameter int unsigned VW         = 10,
   localparam int unsigned AW        = $clog2(CHAR_DEPTH),
   localparam int unsigned SCAN_W    = $clog2(GLYPH_H)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [HW-1:0]     h_i,
   input  logic [VW-1:0]     v_i,
   input  logic              host_we_i,
   input  logic [AW-1:0]     host_addr_i,
   input  char_code_t        host_data_i,
   output logic              char_fetch_o,
   output logic              glyph_fetch_o,
   output logic              shift_load_o,
   output char_code_t        code_o,
   output logic [SCAN_W-1:0] scan_o
);

   localparam int unsigned FETCH_FIRST = H_START - PRIME_LEAD;
   localparam int unsigned FETCH_SPAN  = COLS * GLYPH_W;
   localparam int unsigned PW          = $clog2(GLYPH_W);

   char_code_t        mem [CHAR_DEPTH];
   char_code_t        code_q;
   logic [SCAN_W-1:0] scan_q;
   logic              glyph_q, shift_q;

   logic              vis_line, in_span, phase0, char_fetch;
   logic [HW-1:0]     h_rel;
   logic [VW-1:0]     v_rel;
   logic [31:0]       row_w, col_w, lin_w;
   logic [AW-1:0]     rd_addr;

   always_comb begin
      vis_line   = (v_i >= VW'(V_START)) && (v_i < VW'(V_START + V_ACTIVE));
      h_rel      = h_i - HW'(FETCH_FIRST);
      in_span    = (h_i >= HW'(FETCH_FIRST)) && (h_rel < HW'(FETCH_SPAN));
      phase0     = (h_rel[PW-1:0] == '0);
      char_fetch = vis_line && in_span && phase0;
      v_rel      = v_i - VW'(V_START);
      row_w      = 32'(v_rel >> SCAN_W);
      col_w      = 32'(h_rel >> PW);
      lin_w      = row_w * COLS + col_w;
      rd_addr    = lin_w[AW-1:0];
   end

   // Host write port of the character store
   always_ff @(posedge clk_i) begin
      if (host_we_i && (32'(host_addr_i) < CHAR_DEPTH)) begin
         mem[host_addr_i] <= host_data_i;
      end
   end

   // Registered read of the character store, scan row travels alongside
   always_ff @(posedge clk_i) begin
      if (char_fetch) begin
         code_q <= mem[rd_addr];
         scan_q <= v_rel[SCAN_W-1:0];
      end
   end

   // Strobe pipeline: font read one clock later, shift load one more
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         glyph_q <= 1'b0;
         shift_q <= 1'b0;
      end else begin
         glyph_q <= char_fetch;
         shift_q <= glyph_q;
      end
   end

   assign char_fetch_o  = char_fetch;
   assign glyph_fetch_o = glyph_q;
   assign shift_load_o  = shift_q;
   assign code_o        = code_q;
   assign scan_o        = scan_q;

   assert_strobes_disjoint_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      char_fetch |-> (!glyph_q && !shift_q));

   assert_fetch_in_store_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      char_fetch |-> (32'(rd_addr) < CHAR_DEPTH));

endmodule

// File: rtl/txtvid_font.sv
module txtvid_font
   import txtvid_pkg::*;
#(
   localparam int unsigned SCAN_W = $clog2(GLYPH_H),
   localparam int unsigned FAW    = $clog2(FONT_DEPTH)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              fetch_i,
   input  char_code_t        code_i,
   input  logic [SCAN_W-1:0] scan_i,
   output glyph_row_t        row_o
);

   glyph_row_t    rom [FONT_DEPTH];
   glyph_row_t    row_q;
   logic          valid;
   char_code_t    glyph_idx;
   logic [31:0]   addr_w;
   logic [FAW-1:0] addr;

   initial begin
      for (int unsigned a = 0; a < FONT_DEPTH; a++) begin
         rom[a] = font_pattern(a);
      end
   end

   always_comb begin
      valid     = (32'(code_i) >= FIRST_CODE) && (32'(code_i) < FIRST_CODE + GLYPH_COUNT);
      glyph_idx = code_i - CODE_W'(FIRST_CODE);
      addr_w    = 32'(glyph_idx) * GLYPH_H + 32'(scan_i);
      addr      = addr_w[FAW-1:0];
   end

   // Codes outside the printable range read as an empty row
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         row_q <= '0;
      end else if (fetch_i) begin
         row_q <= valid ? rom[addr] : '0;
      end
   end

   assign row_o = row_q;

endmodule

// File: rtl/txtvid_serializer.sv
module txtvid_serializer
   import txtvid_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       load_i,
   input  glyph_row_t row_i,
   input  logic       active_i,
   output logic       pixel_o
);

   glyph_row_t sr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= row_i;
      end else begin
         sr_q <= {sr_q[GLYPH_W-2:0], 1'b0};
      end
   end

   assign pixel_o = sr_q[GLYPH_W-1] & active_i;

   assert_drained_at_blank_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(active_i) |-> (sr_q == '0));

endmodule

// File: rtl/txtvid_chargen.sv
module txtvid_chargen
   import txtvid_pkg::*;
#(
   parameter int unsigned H_TOTAL    = 800,
   parameter int unsigned H_SYNC     = 96,
   parameter int unsigned H_START    = 144,
   parameter int unsigned COLS       = 80,
   parameter int unsigned V_TOTAL    = 525,
   parameter int unsigned V_SYNC     = 2,
   parameter int unsigned V_START    = 35,
   parameter int unsigned V_ACTIVE   = 480,
   parameter int unsigned CHAR_DEPTH = 2560,
   parameter bit          SYNC_HIGH  = 1'b1,
   localparam int unsigned AW        = $clog2(CHAR_DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          host_we_i,
   input  logic [AW-1:0] host_addr_i,
   input  logic [7:0]    host_data_i,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          active_o,
   output logic          pixel_o,
   output logic          char_fetch_o,
   output logic          glyph_fetch_o,
   output logic          shift_load_o
);

   localparam int unsigned H_VISIBLE = COLS * GLYPH_W;
   localparam int unsigned ROWS      = V_ACTIVE / GLYPH_H;
   localparam int unsigned HW        = $clog2(H_TOTAL + 1);
   localparam int unsigned VW        = $clog2(V_TOTAL + 1);
   localparam int unsigned SCAN_W    = $clog2(GLYPH_H);

   // Elaboration-time parameter checks
   generate
      if (H_START < PRIME_LEAD) begin : g_chk_lead
         $error("H_START leaves no room for the fetch lead");
      end
      if (H_START + H_VISIBLE > H_TOTAL) begin : g_chk_hspan
         $error("visible span exceeds the line length");
      end
      if (V_START + V_ACTIVE > V_TOTAL) begin : g_chk_vspan
         $error("visible lines exceed the frame length");
      end
      if (V_ACTIVE % GLYPH_H != 0) begin : g_chk_rows
         $error("visible lines must be a whole number of text rows");
      end
      if (CHAR_DEPTH < COLS * ROWS) begin : g_chk_depth
         $error("character store too small for the screen");
      end
      if (CODE_W != 8) begin : g_chk_code
         $error("host data port assumes 8-bit codes");
      end
   endgenerate

   logic [HW-1:0]     h;
   logic [VW-1:0]     v;
   logic              act;
   logic              c_fetch, g_fetch, s_load;
   char_code_t        code;
   logic [SCAN_W-1:0] scan;
   glyph_row_t        glyph_row;

   txtvid_timing #(
      .H_TOTAL  (H_TOTAL),
      .H_SYNC   (H_SYNC),
      .H_START  (H_START),
      .H_VISIBLE(H_VISIBLE),
      .V_TOTAL  (V_TOTAL),
      .V_SYNC   (V_SYNC),
      .V_START  (V_START),
      .V_ACTIVE (V_ACTIVE),
      .SYNC_HIGH(SYNC_HIGH)
   ) timing_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .h_o     (h),
      .v_o     (v),
      .hsync_o (hsync_o),
      .vsync_o (vsync_o),
      .active_o(act)
   );

   txtvid_fetch #(
      .H_START   (H_START),
      .COLS      (COLS),
      .V_START   (V_START),
      .V_ACTIVE  (V_ACTIVE),
      .CHAR_DEPTH(CHAR_DEPTH),
      .HW        (HW),
      .VW        (VW)
   ) fetch_i (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .h_i          (h),
      .v_i          (v),
      .host_we_i    (host_we_i),
      .host_addr_i  (host_addr_i),
      .host_data_i  (host_data_i),
      .char_fetch_o (c_fetch),
      .glyph_fetch_o(g_fetch),
      .shift_load_o (s_load),
      .code_o       (code),
      .scan_o       (scan)
   );

   txtvid_font font_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .fetch_i(g_fetch),
      .code_i (code),
      .scan_i (scan),
      .row_o  (glyph_row)
   );

   txtvid_serializer ser_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (s_load),
      .row_i   (glyph_row),
      .active_i(act),
      .pixel_o (pixel_o)
   );

   assign active_o      = act;
   assign char_fetch_o  = c_fetch;
   assign glyph_fetch_o = g_fetch;
   assign shift_load_o  = s_load;

   assert_load_precedes_pixels_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      s_load |=> act);

   assert_glyph_after_char_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(g_fetch) |-> $fell(c_fetch));

endmodule

// File: tb/txtvid_chargen_tb_top.sv
module txtvid_chargen_tb_top;
   timeunit 1ns;
   timeprecision 1ns;

   localparam int H_TOTAL  = 800;
   localparam int H_START  = 144;
   localparam int COLS     = 80;
   localparam int V_TOTAL  = 40;
   localparam int V_SYNC   = 2;
   localparam int V_START  = 3;
   localparam int V_ACTIVE = 32;
   localparam int DEPTH    = 2560;
   localparam int NSAMP    = 2 * V_TOTAL * H_TOTAL + 50;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        we  = 1'b0;
   logic [11:0] waddr = '0;
   logic [7:0]  wdata = '0;
   logic        hsync, vsync, active, pixel, cfetch, gfetch, sload;

   always #10 clk = ~clk;

   txtvid_chargen #(
      .V_TOTAL (V_TOTAL),
      .V_SYNC  (V_SYNC),
      .V_START (V_START),
      .V_ACTIVE(V_ACTIVE)
   ) dut_i (
      .clk_i        (clk),
      .rst_i        (rst),
      .host_we_i    (we),
      .host_addr_i  (waddr),
      .host_data_i  (wdata),
      .hsync_o      (hsync),
      .vsync_o      (vsync),
      .active_o     (active),
      .pixel_o      (pixel),
      .char_fetch_o (cfetch),
      .glyph_fetch_o(gfetch),
      .shift_load_o (sload)
   );

   int         checks = 0;
   int         bad    = 0;
   bit         finished = 1'b0;
   logic [7:0] shadow [DEPTH];
   logic [6:0] exp_q [$];
   string      tag_q [$];
   int         mh = 0, mv = 0, frm = 0;

   function automatic logic [7:0] glyph_byte(input logic [7:0] code, input int s);
      int a;
      if (code < 8'd32 || code > 8'd127) return 8'h00;
      a = (int'(code) - 32) * 16 + s;
      if (a < 16) return 8'h00;
      return 8'((a * 37 + 11) % 256);
   endfunction

   // Expected {hsync, vsync, active, pixel, char, glyph, shift}
   function automatic logic [6:0] predict(input int h, input int v, output string tag);
      logic hs, vs, vis, act, pix, cf, gf, sl;
      logic [7:0] code, row;
      int rel, col, b;
      hs  = (h < 96);
      vs  = (v < V_SYNC);
      vis = (v >= V_START) && (v < V_START + V_ACTIVE);
      act = vis && (h >= H_START) && (h < H_START + COLS * 8);
      cf  = vis && (h >= 141) && (h <= 773) && ((h - 141) % 8 == 0);
      gf  = vis && (h >= 142) && (h <= 774) && ((h - 142) % 8 == 0);
      sl  = vis && (h >= 143) && (h <= 775) && ((h - 143) % 8 == 0);
      pix = 1'b0;
      tag = "R8";
      if (act) begin
         rel  = v - V_START;
         col  = (h - H_START) / 8;
         b    = (h - H_START) % 8;
         code = shadow[(rel / 16) * COLS + col];
         row  = glyph_byte(code, rel % 16);
         pix  = row[7 - b];
         if (code < 8'd32 || code > 8'd127) tag = "R7";
         else if (code == 8'd32)            tag = "R6";
         else if (frm > 0)                  tag = "R9";
         else                               tag = "R5";
      end
      return {hs, vs, act, pix, cf, gf, sl};
   endfunction

   task automatic check_bit(input string req, input string name, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s h=%0d v=%0d actual=%b expected=%b", req, name, mh, mv, act, exp);
      end
   endtask

   // Monitor: pops the oldest expectation and compares it with the outputs
   task automatic monitor_pop();
      logic [6:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_bit("R1", "hsync",  hsync,  e[6]);
      check_bit("R2", "vsync",  vsync,  e[5]);
      check_bit("R3", "active", active, e[4]);
      check_bit(t,    "pixel",  pixel,  e[3]);
      check_bit("R4", "char_fetch",  cfetch, e[2]);
      check_bit("R4", "glyph_fetch", gfetch, e[1]);
      check_bit("R4", "shift_load",  sload,  e[0]);
   endtask

   task automatic host_write(input int addr, input logic [7:0] data);
      @(negedge clk);
      we    = 1'b1;
      waddr = 12'(addr);
      wdata = data;
      shadow[addr] = data;
   endtask

   function automatic logic [7:0] pattern(input int variant, input int r, input int c);
      logic [7:0] code;
      if (variant == 0) begin
         code = 8'(32 + ((c * 7 + r * 11) % 96));
         if (r == 0 && c == 0)  code = 8'h41;
         if (r == 0 && c == 1)  code = 8'h20;
         if (r == 0 && c == 2)  code = 8'h05;
         if (r == 0 && c == 3)  code = 8'h80;
         if (r == 0 && c == 4)  code = 8'h7F;
         if (r == 0 && c == 5)  code = 8'h1F;
         if (r == 1 && c == 10) code = 8'hFF;
         if (r == 1 && c == 79) code = 8'h20;
      end else begin
         code = 8'(32 + ((c * 13 + r * 5 + 3) % 96));
         if (r == 1 && c == 0)  code = 8'h00;
      end
      return code;
   endfunction

   task automatic fill_frame(input int variant);
      for (int r = 0; r < V_ACTIVE / 16; r++) begin
         for (int c = 0; c < COLS; c++) begin
            host_write(r * COLS + c, pattern(variant, r, c));
         end
      end
      @(negedge clk);
      we = 1'b0;
   endtask

   // Driver for the mid-run rewrite (R9), placed in vertical blanking
   task automatic drive_rewrite();
      wait (frm == 0 && mv == V_START + V_ACTIVE + 1);
      fill_frame(1);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      string t;
      for (int i = 0; i < DEPTH; i++) shadow[i] = 8'h00;
      repeat (3) @(negedge clk);
      fill_frame(0);
      // R10: state held by reset
      check_bit("R10", "hsync",       hsync,  1'b1);
      check_bit("R10", "vsync",       vsync,  1'b1);
      check_bit("R10", "active",      active, 1'b0);
      check_bit("R10", "pixel",       pixel,  1'b0);
      check_bit("R10", "char_fetch",  cfetch, 1'b0);
      check_bit("R10", "glyph_fetch", gfetch, 1'b0);
      check_bit("R10", "shift_load",  sload,  1'b0);
      rst = 1'b0;
      fork
         drive_rewrite();
      join_none
      for (int n = 0; n < NSAMP; n++) begin
         exp_q.push_back(predict(mh, mv, t));
         tag_q.push_back(t);
         monitor_pop();
         mh++;
         if (mh == H_TOTAL) begin
            mh = 0;
            mv++;
            if (mv == V_TOTAL) begin
               mv = 0;
               frm++;
            end
         end
         @(negedge clk);
      end
      finished = 1'b1;
      finish_run();
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++;
         bad++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         finish_run();
      end
   end

endmodule